// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

This block is an 8-pin general-purpose I/O port that software drives through a small register interface. Each pin has a direction bit and an output latch bit. A pin whose direction bit is 0 drives its latch bit onto an external tristate pad. A pin whose direction bit is 1 floats its driver and acts as an input. Pin levels pass through a two-flop synchronizer before software can read them.

Reads return three different views. The latch view returns the stored output value, so a read-modify-write of that value is not corrupted by loading on the pins. The pin view returns the synchronized pad levels. The direction view returns the direction bits. A write to either the pin view or the latch view loads the same output latch.

An ownership input gives the pads to an external bus function. While the bus owns the pads, the pad enable and pad data come straight from the bus inputs. Register writes still land during that time, so the stored GPIO settings take effect as soon as the bus releases the pads.

The register select is a named enumeration with four values:

| Select | Code | Behaviour |
|---|---|---|
| SEL_PIN | 0 | Read returns the synchronized pins; write loads the latch |
| SEL_LAT | 1 | Read returns the latch; write loads the latch |
| SEL_DIR | 2 | Read returns the direction bits; write loads them |
| SEL_NONE | 3 | Read returns 0x00; write has no effect |

The block has no state machine. The decode is a `unique case` over this enumeration.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction bits are all 1 (0xFF), the latch is 0x00 and `rd_data` is 0x00. While `bus_own` is 0, `pad_oe` is therefore 0x00.
- R2: While `bus_own` is 0, pin i has `pad_oe[i]` = 1 exactly when direction bit i is 0, and `pad_out[i]` equals latch bit i.
- R3: A write strobe with address 0 (pin view) or address 1 (latch view) loads `wr_data` into the latch on that clock edge.
- R4: A read at address 1 returns the latch contents, whatever the levels on `pin_in`.
- R5: A read at address 0 returns `pin_in` delayed by two clock edges. A pin change made just before edge e is returned by a read strobed at edge e+2, and not by reads strobed at edges e or e+1.
- R6: A write at address 2 loads the direction bits, and a read at address 2 returns them.
- R7: While `bus_own` is 1, `pad_oe` equals `bus_oe` and `pad_out` equals `bus_out`, whatever the register contents.
- R8: Writes made while `bus_own` is 1 still update the latch and the direction bits. Once `bus_own` returns to 0, the pads reflect those values.
- R9: Address 3 is unused. A write to it changes no register, and a read of it returns 0x00.
- R10: `rd_data` is registered. It changes only on an edge where `rd_en` is 1, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select (0 pin, 1 latch, 2 direction, 3 unused) |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin pad driver enable, 1 = drive |
| pad_out | output | 8 | Per-pin pad drive value |
| bus_own | input | 1 | 1 = external bus function owns the pads |
| bus_oe | input | 8 | Bus function driver enables |
| bus_out | input | 8 | Bus function drive values |

## Verification
The assertions check on every cycle that a write at the matching address loads the latch or the direction bits, that no register changes without a write strobe, that the synchronizer output trails the pins by exactly two edges, and that read data holds between read strobes. Other behaviours can only be shown by the bench scenarios. These are the reset values, the per-pin pad drive for a mixed direction pattern, and the choice between latch and pin values on readback. They also include the handover of the pads to the bus function and back, the values written while the bus owned the pads, and the unused address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN  = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] stg [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= pin_in;
            for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign pin_sync = stg[SYNC_STAGES-1];

    // Counts edges since reset so the lag check starts once the stages hold real samples.
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm <= 2'd0;
        else if (warm != 2'd3)   warm <= warm + 2'd1;
    end

    // R5
    sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (pin_sync == $past(pin_in, 2)))
        else $error("pin synchronizer lag broken");
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    input  logic              rd_en,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      rd_data,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q
);
    reg_sel_e     sel;
    logic         lat_we;
    logic         dir_we;
    logic [W-1:0] rd_mux;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        lat_we = 1'b0;
        dir_we = 1'b0;
        rd_mux = '0;
        unique case (sel)
            SEL_PIN: begin
                lat_we = wr_en;
                rd_mux = pin_sync;
            end
            SEL_LAT: begin
                lat_we = wr_en;
                rd_mux = latch_q;
            end
            SEL_DIR: begin
                dir_we = wr_en;
                rd_mux = dir_q;
            end
            SEL_NONE: begin
                rd_mux = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '1;
        end else begin
            if (lat_we) latch_q <= wr_data;
            if (dir_we) dir_q   <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == SEL_PIN || addr == SEL_LAT)) |=> (latch_q == $past(wr_data)))
        else $error("latch not loaded");

    // R6
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_DIR) |=> (dir_q == $past(wr_data)))
        else $error("direction not loaded");

    // R9
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q)))
        else $error("register changed without write");

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data))
        else $error("read data changed without strobe");
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         bus_own,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] bus_oe,
    input  logic [W-1:0] bus_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (bus_own) begin
                pad_oe[i]  = bus_oe[i];
                pad_out[i] = bus_out[i];
            end else begin
                pad_oe[i]  = ~dir_q[i];
                pad_out[i] = latch_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    input  logic              bus_own,
    input  logic [PORT_W-1:0] bus_oe,
    input  logic [PORT_W-1:0] bus_out
);
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;

    gpio_pin_sync #(.W(PORT_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_regs #(.W(PORT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .pin_sync (pin_sync),
        .rd_data  (rd_data),
        .latch_q  (latch_q),
        .dir_q    (dir_q)
    );

    gpio_pad_mux #(.W(PORT_W)) u_pad (
        .bus_own (bus_own),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .bus_oe  (bus_oe),
        .bus_out (bus_out),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic       bus_own = 1'b0;
    logic [7:0] bus_oe = 8'h00;
    logic [7:0] bus_out = 8'h00;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .bus_own(bus_own), .bus_oe(bus_oe), .bus_out(bus_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        reg_read(2'd2, v); check("R1 dir", v, 8'hFF);
        reg_read(2'd1, v); check("R1 latch", v, 8'h00);
    endtask

    task automatic t_drive;
        logic [7:0] v;
        reg_write(2'd2, 8'hCF);
        reg_write(2'd0, 8'h3A);      // R3 via pin view
        check("R2 pad_oe", pad_oe, 8'h30);
        check("R2 pad_out", pad_out, 8'h3A);
        reg_read(2'd2, v); check("R6 dir readback", v, 8'hCF);
        reg_write(2'd1, 8'hA5);      // R3 via latch view
        check("R3 latch view write", pad_out, 8'hA5);
        reg_write(2'd2, 8'h00);
        check("R2 all outputs", pad_oe, 8'hFF);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        reg_read(2'd1, v); check("R4 latch not pins", v, 8'hA5);
        reg_read(2'd0, v); check("R4 pin view", v, 8'h00);
    endtask

    task automatic t_sync_lag;
        logic [7:0] v;
        @(negedge clk);
        pin_in = 8'h5C;
        addr = 2'd0; rd_en = 1'b1;
        @(negedge clk); check("R5 edge e", rd_data, 8'h00);
        @(negedge clk); check("R5 edge e+1", rd_data, 8'h00);
        @(negedge clk); check("R5 edge e+2", rd_data, 8'h5C);
        rd_en = 1'b0;
        pin_in = 8'hC3;
        repeat (3) @(negedge clk);
        reg_read(2'd0, v); check("R5 settled", v, 8'hC3);
    endtask

    task automatic t_bus;
        logic [7:0] v;
        @(negedge clk);
        bus_oe = 8'h0F; bus_out = 8'h3C; bus_own = 1'b1;
        #1;
        check("R7 pad_oe", pad_oe, 8'h0F);
        check("R7 pad_out", pad_out, 8'h3C);
        reg_write(2'd1, 8'h81);
        reg_write(2'd2, 8'h0F);
        check("R7 still bus oe", pad_oe, 8'h0F);
        check("R7 still bus out", pad_out, 8'h3C);
        @(negedge clk);
        bus_own = 1'b0;
        #1;
        check("R8 oe after release", pad_oe, 8'hF0);
        check("R8 out after release", pad_out, 8'h81);
        reg_read(2'd2, v); check("R8 dir kept", v, 8'h0F);
    endtask

    task automatic t_unused;
        logic [7:0] v;
        reg_write(2'd3, 8'h77);
        reg_read(2'd1, v); check("R9 latch kept", v, 8'h81);
        reg_read(2'd2, v); check("R9 dir kept", v, 8'h0F);
        reg_read(2'd3, v); check("R9 read zero", v, 8'h00);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        reg_read(2'd1, v); check("R10 read", v, 8'h81);
        reg_write(2'd1, 8'h42);
        repeat (2) @(negedge clk);
        check("R10 hold", rd_data, 8'h81);
        reg_read(2'd1, v); check("R10 new read", v, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drive();
        t_readback();
        t_sync_lag();
        t_bus();
        t_unused();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule